// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver with Runtime Promotion

This block chooses which pending interrupt a small microcontroller core services next. It takes sixteen maskable request lines and one nonmaskable request, together with the core's interrupt-mask bit. Each clock it registers a winner: a source index, a flag that marks the nonmaskable case, and a valid bit. The core uses these to select a vector.

The maskable sources have a fixed descending order. A 4-bit promotion field in a small control register can lift any one source above all the others. The field can change only while the core has interrupts masked, so the order cannot shift under a pending decision.

The same register holds two mode bits: an alternate-mode flag and an internal-read-visibility flag. Both can be written only in special mode. The visibility flag clears itself whenever special mode is off.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the promotion field reads 6 (IRQ), both mode bits read 0, and `win_valid` is 0.
- R2: A nonmaskable request wins whatever the mask and the maskable requests are. The registered output then shows `win_valid`=1, `win_nmi`=1 and `win_idx`=0.
- R3: While `cpu_mask` is 1, maskable requests produce no output (`win_valid`=0 when there is no nonmaskable request).
- R4: When unmasked and the promoted source is requesting, that source wins over every other maskable request.
- R5: Request bit i is source code i. Codes map as: 0 timer overflow, 1 pulse-accumulator overflow, 2 pulse-accumulator edge, 3 SPI, 4 SCI, 5 reserved, 6 IRQ, 7 real-time, 8 to 10 input capture 1 to 3, 11 to 15 output compare 1 to 5. Non-promoted sources win in this fixed order, highest first: 6, 7, 8 up to 15, then 0, 1, 2, 3, 4.
- R6: Promotion code 5 promotes IRQ (code 6). Request bit 5 is never eligible to win.
- R7: A write to the promotion field (`cfg_wdata[3:0]`) takes effect only while `cpu_mask` is 1. A write while `cpu_mask` is 0 leaves the field unchanged.
- R8: The mode bits (`cfg_wdata[6]` alternate mode, `cfg_wdata[7]` read visibility) are written only while `special_mode` is 1. Otherwise they keep their values.
- R9: The read-visibility bit (`cfg_rdata[7]`) reads 0 from the cycle after any cycle in which `special_mode` is 0.
- R10: The winner is registered. The output seen after a clock edge reflects the inputs sampled at that edge. `win_valid` is 0 when no request is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Maskable request lines, bit i is source code i |
| nmi_req | input | 1 | Nonmaskable request |
| cpu_mask | input | 1 | Core interrupt-mask bit (1 = masked) |
| special_mode | input | 1 | Special operating mode active |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Write data: [3:0] promotion, [6] alternate mode, [7] read visibility |
| cfg_rdata | output | 8 | Control register readback, same layout, bits [5:4] read 0 |
| win_valid | output | 1 | A winner is reported |
| win_nmi | output | 1 | The winner is the nonmaskable request |
| win_idx | output | 4 | Winning maskable source code |

## Verification
The bench walks through all sixteen promotion codes with random request patterns and compares each result against an independent model. A resolver that mishandled the wrap from output compare 5 to timer overflow, or that let reserved bit 5 win, would report the wrong index. It rewrites the promotion field while unmasked and then confirms that the old source still wins; a design that ignored the mask gate would move priority under a live request. It also holds a nonmaskable request against a promoted maskable one while masked, and clears special mode under a set visibility bit. A design that got these wrong would report a maskable winner or keep the visibility bit readable.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int NUM_SRC   = 16,
  parameter int IRQ_CODE  = 6,
  parameter int RSVD_CODE = 5,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               cpu_mask,
  input  logic               special_mode,
  input  logic               cfg_wr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic               win_valid,
  output logic               win_nmi,
  output logic [IDX_W-1:0]   win_idx
);
  localparam int UPPER = NUM_SRC - IRQ_CODE;

  logic [IDX_W-1:0]   promo_q;
  logic               alt_q, vis_q;
  logic [IDX_W-1:0]   promo_eff, pick;
  logic [NUM_SRC-1:0] elig;

  assign promo_eff = (promo_q == IDX_W'(RSVD_CODE)) ? IDX_W'(IRQ_CODE) : promo_q;
  assign elig      = irq_req & ~(NUM_SRC'(1) << RSVD_CODE);
  assign cfg_rdata = {vis_q, alt_q, 2'b00, promo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promo_q <= IDX_W'(IRQ_CODE);
      alt_q   <= 1'b0;
      vis_q   <= 1'b0;
    end else begin
      if (cfg_wr && cpu_mask) promo_q <= cfg_wdata[IDX_W-1:0];
      if (cfg_wr && special_mode) alt_q <= cfg_wdata[6];
      if (!special_mode) vis_q <= 1'b0;
      else if (cfg_wr) vis_q <= cfg_wdata[7];
    end
  end

  always_comb begin
    pick = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (k < UPPER) begin
        if (elig[k + IRQ_CODE]) pick = IDX_W'(k + IRQ_CODE);
      end else begin
        if (elig[k - UPPER]) pick = IDX_W'(k - UPPER);
      end
    end
    if (elig[promo_eff]) pick = promo_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_nmi   <= 1'b0;
      win_idx   <= '0;
    end else if (nmi_req) begin
      win_valid <= 1'b1;
      win_nmi   <= 1'b1;
      win_idx   <= '0;
    end else begin
      win_valid <= !cpu_mask && (|elig);
      win_nmi   <= 1'b0;
      win_idx   <= (!cpu_mask && (|elig)) ? pick : '0;
    end
  end
endmodule

module irq_prio_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] irq_req,
  input logic        nmi_req,
  input logic        cpu_mask,
  input logic        special_mode,
  input logic        cfg_wr,
  input logic [7:0]  cfg_rdata,
  input logic        win_valid,
  input logic        win_nmi,
  input logic [3:0]  win_idx
);
  logic [3:0] p;
  assign p = (cfg_rdata[3:0] == 4'd5) ? 4'd6 : cfg_rdata[3:0];

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> (win_valid && win_nmi && win_idx == 4'd0)); // R2
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && cpu_mask) |=> !win_valid); // R3
  AST_PROMOTED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && !cpu_mask && irq_req[p]) |=> (win_valid && win_idx == $past(p))); // R4
  AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_nmi) |-> win_idx != 4'd5); // R6
  AST_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cpu_mask) |=> $stable(cfg_rdata[3:0])); // R7
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode) |=> ($stable(cfg_rdata[6]) && !cfg_rdata[7])); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && (irq_req & 16'hffdf) == 16'h0) |=> !win_valid); // R10
endmodule

bind irq_prio_resolver irq_prio_resolver_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
  .cpu_mask(cpu_mask), .special_mode(special_mode), .cfg_wr(cfg_wr),
  .cfg_rdata(cfg_rdata), .win_valid(win_valid), .win_nmi(win_nmi),
  .win_idx(win_idx)
);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        nmi_req = 1'b0, cpu_mask = 1'b1, special_mode = 1'b0, cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        win_valid, win_nmi;
  logic [3:0]  win_idx;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_resolver dut_i (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {valid, nmi, idx}
  function automatic logic [5:0] ref_win(logic [15:0] r, logic [3:0] pr, logic nmi, logic msk);
    logic [3:0] pe;
    logic [15:0] el;
    if (nmi) return {2'b11, 4'd0};
    el = r & 16'hffdf;
    if (msk || el == 0) return 6'd0;
    pe = (pr == 4'd5) ? 4'd6 : pr;
    if (el[pe]) return {2'b10, pe};
    for (int k = 0; k < 15; k++) begin
      int c = (k < 10) ? k + 6 : k - 10;
      if (el[c]) return {2'b10, 4'(c)};
    end
    return 6'd0;
  endfunction

  task automatic write_cfg(logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic apply(logic [15:0] r, logic nmi, logic msk, string req);
    logic [3:0] pr = cfg_rdata[3:0];
    @(negedge clk); irq_req = r; nmi_req = nmi; cpu_mask = msk;
    @(negedge clk);
    chk(req, {10'd0, win_valid, win_nmi, win_idx}, {10'd0, ref_win(r, pr, nmi, msk)});
  endtask

  task automatic t_reset;
    chk("R1 promo", {12'd0, cfg_rdata[3:0]}, 16'd6);
    chk("R1 mode", {14'd0, cfg_rdata[7:6]}, 16'd0);
    chk("R1 valid", {15'd0, win_valid}, 16'd0);
  endtask

  task automatic t_nmi;
    apply(16'hffff, 1'b1, 1'b1, "R2 masked");
    apply(16'h0040, 1'b1, 1'b0, "R2 unmasked");
  endtask

  task automatic t_mask;
    apply(16'hffff, 1'b0, 1'b1, "R3 all masked");
    apply(16'h0000, 1'b0, 1'b0, "R10 idle");
    apply(16'h0020, 1'b0, 1'b0, "R6 reserved only");
  endtask

  task automatic t_order;
    apply(16'h001f, 1'b0, 1'b0, "R5 wrap low group");
    apply(16'h8001, 1'b0, 1'b0, "R5 OC5 over TOF");
    apply(16'h0010, 1'b0, 1'b0, "R5 SCI alone");
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 16; c++) begin
      cpu_mask = 1'b1;
      write_cfg(8'(c));
      chk("R7 masked write", {12'd0, cfg_rdata[3:0]}, 16'(c));
      apply(16'hffff, 1'b0, 1'b0, "R4 all requesting");
      for (int i = 0; i < 6; i++) apply(16'($urandom), 1'b0, 1'b0, "R4/R5 random");
      apply(16'h0040 | (16'd1 << c), 1'b0, 1'b0, "R6 promo vs IRQ");
    end
  endtask

  task automatic t_wr_reject;
    cpu_mask = 1'b1; write_cfg(8'd15);
    cpu_mask = 1'b0; write_cfg(8'd0);
    chk("R7 unmasked write", {12'd0, cfg_rdata[3:0]}, 16'd15);
    apply(16'h8001, 1'b0, 1'b0, "R7 old promo holds");
  endtask

  task automatic t_mode;
    special_mode = 1'b0; write_cfg(8'hc0 | cfg_rdata[3:0]);
    chk("R8 locked", {14'd0, cfg_rdata[7:6]}, 16'd0);
    special_mode = 1'b1; write_cfg(8'hc0 | cfg_rdata[3:0]);
    chk("R8 special write", {14'd0, cfg_rdata[7:6]}, 16'd3);
    @(negedge clk); special_mode = 1'b0;
    @(negedge clk);
    chk("R9 vis cleared", {14'd0, cfg_rdata[7:6]}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_nmi; t_mask; t_order; t_sweep; t_wr_reject; t_mode;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule